// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block holds the status byte of a serial NOR flash device and rules on every write-class command before the array sees it. The instruction decoder upstream presents one decoded command per cycle, together with its target address and, for a status write, the data byte. The block answers one cycle later with an accept or a reject pulse. It updates the write-enable latch, the protection field, the protection lock, the one-way identity lock and the sequential-program mode. It also raises busy for the array engine and drops it on that engine's completion pulse.

Protection covers a 2^ADDR_W byte space (1 MB by default). A 3-bit code selects a protected region at the top of the array: the top 1/16, 1/8, 1/4 or 1/2, or the whole array. In sequential-program mode, one start command is followed by single-step commands that each advance an internal pointer by one location. This mode ends on an explicit end command or a write-disable. It also ends by itself when the location just programmed is the last one below the protected region or at the top of the space.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x1C. Its layout is bit0 busy, bit1 write-enable, bits 4:2 protection code, bit5 identity lock, bit6 sequential mode, bit7 protection lock. accept_o and reject_o are low.
- R2: Command codes are 1 set-enable, 2 clear-enable, 3 status write, 4 program, 5 sequence start, 6 sequence step, 7 sequence end, 8 sector erase, 9 block erase, 10 chip erase, 11 identity program, 12 identity lock. A command with cmd_valid_i high gives exactly one of accept_o or reject_o in the next cycle. Codes 0 and 13..15 are rejected, and idle cycles give neither pulse.
- R3: Set-enable sets the write-enable bit. Clear-enable clears it.
- R4: With write-enable at 0, status write, program, sequence start, the erases and both identity commands are rejected.
- R5: Any command arriving while busy is 1 is rejected and changes nothing.
- R6: Protection code 0 protects nothing. Codes 1..4 protect addresses at or above 2^ADDR_W − 2^(ADDR_W−5+code). Codes 5..7 protect everything. Program, sector erase, block erase and sequence start aimed at a protected address are rejected and leave write-enable set.
- R7: Chip erase is accepted only when the protection code is 0.
- R8: An accepted program, erase or identity program sets busy in the next cycle. The completion pulse op_done_i then clears both busy and write-enable.
- R9: An accepted status write loads the protection code from data bits 4:2 and the protection lock from bit 7, and clears write-enable. It is rejected when wp_pin_i is low and the protection lock is 1. With wp_pin_i high the lock has no effect.
- R10: Identity lock sets bit5 and clears write-enable. Nothing clears bit5 afterwards. Identity program is rejected once bit5 is 1.
- R11: Sequence start sets bit6 and busy. While bit6 is 1 and busy is 0, step is accepted (pointer +1, busy set), and end or clear-enable is accepted (bit6 and write-enable cleared). Every other code is rejected.
- R12: A completion in sequential mode, when the next location is protected or past the top of the space, clears bit6 and write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| cmd_valid_i | input | 1 | A decoded command is present |
| cmd_i | input | 4 | Command code (see R2) |
| addr_i | input | ADDR_W | Target byte address |
| sr_data_i | input | 8 | Status write data byte |
| wp_pin_i | input | 1 | Write-protect pin level, low asserts |
| op_done_i | input | 1 | Array engine completion pulse |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | Previous-cycle command accepted |
| reject_o | output | 1 | Previous-cycle command refused |
| busy_o | output | 1 | Internal operation running |

## Verification
The bench probes each protection code at its exact boundary, one address below and at the region base, because an off-by-one region size would accept a program into the first protected location. It writes the status byte with the pin low and the lock set, then with the pin high. A design that ignored the pin would stay locked forever, and one that ignored the lock would let protection be dropped. It walks a sequential program up to the last unprotected location: a design without the auto-exit would leave the mode and write-enable set. It also retries identity lock and program after locking, to catch a lock bit that can be cleared. A long random run then checks response and status every cycle against a bench model.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [3:0] {
    CMD_NONE       = 4'd0,
    CMD_WR_EN      = 4'd1,
    CMD_WR_DIS     = 4'd2,
    CMD_SR_WRITE   = 4'd3,
    CMD_PROG       = 4'd4,
    CMD_SEQ_START  = 4'd5,
    CMD_SEQ_STEP   = 4'd6,
    CMD_SEQ_END    = 4'd7,
    CMD_SECT_ERASE = 4'd8,
    CMD_BLK_ERASE  = 4'd9,
    CMD_CHIP_ERASE = 4'd10,
    CMD_ID_PROG    = 4'd11,
    CMD_ID_LOCK    = 4'd12
  } cmd_e;

  // status byte bit positions
  localparam int ST_BUSY    = 0;
  localparam int ST_WEN     = 1;
  localparam int ST_PROT_LO = 2;
  localparam int ST_PROT_W  = 3;
  localparam int ST_IDLK    = 5;
  localparam int ST_SEQ     = 6;
  localparam int ST_PLK     = 7;

  // first protection code that covers the whole array
  localparam int PROT_FULL_CODE = 5;

  typedef struct packed {
    logic set_wen;
    logic clr_wen;
    logic start_op;
    logic seq_enter;
    logic seq_exit;
    logic seq_step;
    logic sr_load;
    logic id_lock;
  } action_t;

endpackage

// File: rtl/wp_range_check.sv
module wp_range_check
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ST_PROT_W-1:0] prot_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 hit_o
);

  localparam int LOW_BASE = ADDR_W - PROT_FULL_CODE;

  always_comb begin
    if (prot_i == '0) begin
      hit_o = 1'b0;
    end else if (int'(prot_i) >= PROT_FULL_CODE) begin
      hit_o = 1'b1;
    end else begin
      // region is the top 2^(LOW_BASE+code) bytes: all bits above must be ones
      hit_o = 1'b1;
      for (int b = 0; b < ADDR_W; b++) begin
        if (b >= LOW_BASE + int'(prot_i) && !addr_i[b]) hit_o = 1'b0;
      end
    end
  end

endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
  import flash_wp_pkg::*;
(
  input  logic                 cmd_valid_i,
  input  cmd_e                 cmd_i,
  input  logic                 busy_i,
  input  logic                 wen_i,
  input  logic [ST_PROT_W-1:0] prot_i,
  input  logic                 prot_lock_i,
  input  logic                 id_lock_i,
  input  logic                 seq_mode_i,
  input  logic                 wp_pin_i,
  input  logic                 addr_hit_i,
  output logic                 accept_o,
  output action_t              act_o
);

  logic sr_locked;
  assign sr_locked = !wp_pin_i && prot_lock_i;

  always_comb begin
    act_o    = '0;
    accept_o = 1'b0;
    if (cmd_valid_i && !busy_i) begin
      if (seq_mode_i) begin
        case (cmd_i)
          CMD_SEQ_STEP: begin
            accept_o       = 1'b1;
            act_o.seq_step = 1'b1;
            act_o.start_op = 1'b1;
          end
          CMD_SEQ_END, CMD_WR_DIS: begin
            accept_o       = 1'b1;
            act_o.seq_exit = 1'b1;
            act_o.clr_wen  = 1'b1;
          end
          default: ;
        endcase
      end else begin
        case (cmd_i)
          CMD_WR_EN: begin
            accept_o      = 1'b1;
            act_o.set_wen = 1'b1;
          end
          CMD_WR_DIS: begin
            accept_o      = 1'b1;
            act_o.clr_wen = 1'b1;
          end
          CMD_SR_WRITE: begin
            if (wen_i && !sr_locked) begin
              accept_o      = 1'b1;
              act_o.sr_load = 1'b1;
              act_o.clr_wen = 1'b1;
            end
          end
          CMD_PROG, CMD_SECT_ERASE, CMD_BLK_ERASE: begin
            if (wen_i && !addr_hit_i) begin
              accept_o       = 1'b1;
              act_o.start_op = 1'b1;
            end
          end
          CMD_SEQ_START: begin
            if (wen_i && !addr_hit_i) begin
              accept_o        = 1'b1;
              act_o.start_op  = 1'b1;
              act_o.seq_enter = 1'b1;
            end
          end
          CMD_CHIP_ERASE: begin
            if (wen_i && prot_i == '0) begin
              accept_o       = 1'b1;
              act_o.start_op = 1'b1;
            end
          end
          CMD_ID_PROG: begin
            if (wen_i && !id_lock_i) begin
              accept_o       = 1'b1;
              act_o.start_op = 1'b1;
            end
          end
          CMD_ID_LOCK: begin
            if (wen_i) begin
              accept_o      = 1'b1;
              act_o.id_lock = 1'b1;
              act_o.clr_wen = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  action_t              act_i,
  input  logic [7:0]           sr_data_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 op_done_i,
  input  logic                 seq_last_i,
  output logic                 busy_o,
  output logic                 wen_o,
  output logic [ST_PROT_W-1:0] prot_o,
  output logic                 prot_lock_o,
  output logic                 id_lock_o,
  output logic                 seq_mode_o,
  output logic [ADDR_W-1:0]    seq_ptr_o
);

  logic                 busy_q, wen_q, plk_q, idlk_q, seq_q;
  logic [ST_PROT_W-1:0] prot_q;
  logic [ADDR_W-1:0]    ptr_q;

  // actions only arrive when idle, completions only count when busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wen_q  <= 1'b0;
      prot_q <= '1;
      plk_q  <= 1'b0;
      idlk_q <= 1'b0;
      seq_q  <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (op_done_i && busy_q) begin
        busy_q <= 1'b0;
        if (!seq_q) begin
          wen_q <= 1'b0;
        end else if (seq_last_i) begin
          seq_q <= 1'b0;
          wen_q <= 1'b0;
        end
      end
      if (act_i.start_op) busy_q <= 1'b1;
      if (act_i.set_wen)  wen_q  <= 1'b1;
      if (act_i.clr_wen)  wen_q  <= 1'b0;
      if (act_i.sr_load) begin
        prot_q <= sr_data_i[ST_PROT_LO +: ST_PROT_W];
        plk_q  <= sr_data_i[ST_PLK];
      end
      if (act_i.id_lock) idlk_q <= 1'b1;
      if (act_i.seq_enter) begin
        seq_q <= 1'b1;
        ptr_q <= addr_i;
      end
      if (act_i.seq_exit) seq_q <= 1'b0;
      if (act_i.seq_step) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign wen_o       = wen_q;
  assign prot_o      = prot_q;
  assign prot_lock_o = plk_q;
  assign id_lock_o   = idlk_q;
  assign seq_mode_o  = seq_q;
  assign seq_ptr_o   = ptr_q;

  a_r10_id_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idlk_q |=> idlk_q);

  a_r8_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && busy_q && !seq_q) |=> (!busy_q && !wen_q));

  a_r12_seq_auto_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && busy_q && seq_q && seq_last_i) |=> (!seq_q && !wen_q));

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              wp_pin_i,
  input  logic              op_done_i,
  output logic [7:0]        status_o,
  output logic              accept_o,
  output logic              reject_o,
  output logic              busy_o
);

  cmd_e                 cmd;
  action_t              act;
  logic                 accept_d;
  logic                 busy, wen, plk, idlk, seq_mode;
  logic [ST_PROT_W-1:0] prot;
  logic [ADDR_W-1:0]    seq_ptr, seq_ptr_next;
  logic                 addr_hit, next_hit, seq_last;
  logic                 accept_q, reject_q;

  assign cmd          = cmd_e'(cmd_i);
  assign seq_ptr_next = seq_ptr + 1'b1;
  assign seq_last     = (&seq_ptr) | next_hit;

  wp_range_check #(.ADDR_W(ADDR_W)) u_addr_chk (
    .prot_i (prot),
    .addr_i (addr_i),
    .hit_o  (addr_hit)
  );

  wp_range_check #(.ADDR_W(ADDR_W)) u_next_chk (
    .prot_i (prot),
    .addr_i (seq_ptr_next),
    .hit_o  (next_hit)
  );

  wp_cmd_gate u_gate (
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd),
    .busy_i      (busy),
    .wen_i       (wen),
    .prot_i      (prot),
    .prot_lock_i (plk),
    .id_lock_i   (idlk),
    .seq_mode_i  (seq_mode),
    .wp_pin_i    (wp_pin_i),
    .addr_hit_i  (addr_hit),
    .accept_o    (accept_d),
    .act_o       (act)
  );

  wp_status_reg #(.ADDR_W(ADDR_W)) u_sr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .sr_data_i   (sr_data_i),
    .addr_i      (addr_i),
    .op_done_i   (op_done_i),
    .seq_last_i  (seq_last),
    .busy_o      (busy),
    .wen_o       (wen),
    .prot_o      (prot),
    .prot_lock_o (plk),
    .id_lock_o   (idlk),
    .seq_mode_o  (seq_mode),
    .seq_ptr_o   (seq_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      accept_q <= accept_d;
      reject_q <= cmd_valid_i && !accept_d;
    end
  end

  assign accept_o = accept_q;
  assign reject_o = reject_q;
  assign busy_o   = busy;
  assign status_o = {plk, seq_mode, idlk, prot, wen, busy};

  a_r2_one_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (accept_o ^ reject_o));

  a_r2_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !(accept_o || reject_o));

  a_r5_busy_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o) |=> reject_o);

  a_r4_needs_wen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !status_o[ST_WEN] && (cmd inside {CMD_SR_WRITE, CMD_PROG,
      CMD_SEQ_START, CMD_SECT_ERASE, CMD_BLK_ERASE, CMD_CHIP_ERASE,
      CMD_ID_PROG, CMD_ID_LOCK})) |=> reject_o);

  a_r7_chip_needs_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd == CMD_CHIP_ERASE && status_o[ST_PROT_LO +: ST_PROT_W] != '0)
      |=> reject_o);

  a_r9_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_pin_i && status_o[ST_PLK]) |=>
      (status_o[ST_PLK] && $stable(status_o[ST_PROT_LO +: ST_PROT_W])));

endmodule

// File: tb/flash_wp_ctrl_bench.sv
module flash_wp_ctrl_bench;

  localparam int AW = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [3:0]    cmd_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    sr_data_i = '0;
  logic          wp_pin_i = 1'b1;
  logic          op_done_i = 1'b0;
  logic [7:0]    status_o;
  logic          accept_o, reject_o, busy_o;

  always #2 clk_i = ~clk_i;

  flash_wp_ctrl #(.ADDR_W(AW)) u_flash_wp_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .addr_i, .sr_data_i,
    .wp_pin_i, .op_done_i, .status_o, .accept_o, .reject_o, .busy_o
  );

  int tests = 0;
  int fails = 0;
  bit reported = 1'b0;

  // reference model state
  bit          m_busy, m_wen, m_plk, m_idlk, m_seq;
  bit [2:0]    m_prot;
  bit [AW-1:0] m_ptr;

  function automatic bit m_hit(bit [2:0] p, bit [AW-1:0] a);
    int unsigned lim;
    if (p == 3'd0) return 1'b0;
    if (p >= 3'd5) return 1'b1;
    lim = (32'h1 << AW) - (32'h1 << (AW - 5 + int'(p)));
    return 32'(a) >= lim;
  endfunction

  function automatic bit [7:0] m_status();
    return {m_plk, m_seq, m_idlk, m_prot, m_wen, m_busy};
  endfunction

  function automatic string tag_of(bit [3:0] c);
    case (c)
      4'd1, 4'd2:        return "R3";
      4'd3:              return "R9";
      4'd4, 4'd8, 4'd9:  return "R6";
      4'd5, 4'd6, 4'd7:  return "R11";
      4'd10:             return "R7";
      4'd11, 4'd12:      return "R10";
      default:           return "R2";
    endcase
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
  endtask

  // one command cycle: drive, advance the model, sample at the next falling edge
  task automatic step(bit cv, bit [3:0] c, bit [AW-1:0] a, bit [7:0] d,
                      bit wp, bit done, string tag);
    bit acc = 1'b0;
    bit last;
    cmd_valid_i = cv; cmd_i = c; addr_i = a; sr_data_i = d;
    wp_pin_i = wp; op_done_i = done;
    last = (m_ptr == '1) || m_hit(m_prot, m_ptr + 1'b1);
    if (done && m_busy) begin
      m_busy = 1'b0;
      if (!m_seq) m_wen = 1'b0;
      else if (last) begin m_seq = 1'b0; m_wen = 1'b0; end
    end else if (cv && !m_busy) begin
      if (m_seq) begin
        case (c)
          4'd6: begin acc = 1; m_ptr = m_ptr + 1'b1; m_busy = 1; end
          4'd7, 4'd2: begin acc = 1; m_seq = 0; m_wen = 0; end
          default: ;
        endcase
      end else begin
        case (c)
          4'd1: begin acc = 1; m_wen = 1; end
          4'd2: begin acc = 1; m_wen = 0; end
          4'd3: if (m_wen && !(!wp && m_plk)) begin
            acc = 1; m_prot = d[4:2]; m_plk = d[7]; m_wen = 0;
          end
          4'd4, 4'd8, 4'd9: if (m_wen && !m_hit(m_prot, a)) begin
            acc = 1; m_busy = 1;
          end
          4'd5: if (m_wen && !m_hit(m_prot, a)) begin
            acc = 1; m_busy = 1; m_seq = 1; m_ptr = a;
          end
          4'd10: if (m_wen && m_prot == 3'd0) begin acc = 1; m_busy = 1; end
          4'd11: if (m_wen && !m_idlk) begin acc = 1; m_busy = 1; end
          4'd12: if (m_wen) begin acc = 1; m_idlk = 1; m_wen = 0; end
          default: ;
        endcase
      end
    end
    @(negedge clk_i);
    check(tag, "accept", int'(accept_o), int'(acc));
    check(tag, "reject", int'(reject_o), int'(cv && !acc));
    check(tag, "status", int'(status_o), int'(m_status()));
  endtask

  task automatic cmd(bit [3:0] c, bit [AW-1:0] a, bit [7:0] d, bit wp, string tag);
    step(1'b1, c, a, d, wp, 1'b0, tag);
  endtask

  task automatic done_pulse(string tag);
    step(1'b0, 4'd0, '0, 8'd0, 1'b1, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd4242);
    m_busy = 0; m_wen = 0; m_plk = 0; m_idlk = 0; m_seq = 0;
    m_prot = 3'b111; m_ptr = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1", "status", int'(status_o), 32'h1C);
    check("R1", "accept", int'(accept_o), 0);
    check("R1", "reject", int'(reject_o), 0);

    cmd(4'd4, 20'h00000, 8'h00, 1, "R4");        // program without enable
    cmd(4'd1, 20'h00000, 8'h00, 1, "R3");        // set enable
    check("R3", "wen bit", int'(status_o[1]), 1);
    cmd(4'd4, 20'h00000, 8'h00, 1, "R6");        // whole array protected
    cmd(4'd10, 20'h0, 8'h00, 1, "R7");           // chip erase with code 111
    cmd(4'd3, 20'h0, 8'h80, 1, "R9");            // code 000, lock 1
    check("R9", "status after write", int'(status_o), 32'h80);
    cmd(4'd1, 20'h0, 8'h00, 0, "R3");
    cmd(4'd3, 20'h0, 8'h04, 0, "R9");            // pin low + lock: refused
    check("R9", "locked reject", int'(reject_o), 1);
    cmd(4'd3, 20'h0, 8'h08, 1, "R9");            // pin high: lock ignored
    check("R9", "unlocked status", int'(status_o), 32'h08);

    cmd(4'd1, 20'h0, 8'h00, 1, "R3");
    cmd(4'd4, 20'hE0000, 8'h00, 1, "R6");        // base of top 128KB
    check("R6", "wen kept", int'(status_o[1]), 1);
    cmd(4'd4, 20'hDFFFF, 8'h00, 1, "R8");        // just below
    check("R8", "busy set", int'(busy_o), 1);
    cmd(4'd1, 20'h0, 8'h00, 1, "R5");            // while busy
    done_pulse("R8");
    check("R8", "idle after done", int'(status_o), 32'h08);

    cmd(4'd1, 20'h0, 8'h00, 1, "R3");
    cmd(4'd3, 20'h0, 8'h00, 1, "R9");
    cmd(4'd1, 20'h0, 8'h00, 1, "R3");
    cmd(4'd10, 20'h0, 8'h00, 1, "R7");
    check("R7", "chip accepted", int'(accept_o), 1);
    done_pulse("R8");

    cmd(4'd1, 20'h0, 8'h00, 1, "R3");
    cmd(4'd3, 20'h0, 8'h04, 1, "R9");            // code 001: top 64KB
    cmd(4'd1, 20'h0, 8'h00, 1, "R3");
    cmd(4'd9, 20'hF0000, 8'h00, 1, "R6");
    cmd(4'd5, 20'hEFFFE, 8'h00, 1, "R11");
    check("R11", "seq start status", int'(status_o), 32'h47);
    done_pulse("R11");
    cmd(4'd6, 20'h0, 8'h00, 1, "R11");           // pointer to EFFFF
    done_pulse("R12");
    check("R12", "auto exit status", int'(status_o), 32'h04);

    cmd(4'd1, 20'h0, 8'h00, 1, "R3");
    cmd(4'd5, 20'h00100, 8'h00, 1, "R11");
    done_pulse("R11");
    cmd(4'd4, 20'h00200, 8'h00, 1, "R11");       // foreign command in seq mode
    check("R11", "foreign rejected", int'(reject_o), 1);
    cmd(4'd7, 20'h0, 8'h00, 1, "R11");
    check("R11", "end status", int'(status_o), 32'h04);

    cmd(4'd1, 20'h0, 8'h00, 1, "R3");
    cmd(4'd12, 20'h0, 8'h00, 1, "R10");
    check("R10", "lock status", int'(status_o), 32'h24);
    cmd(4'd1, 20'h0, 8'h00, 1, "R3");
    cmd(4'd11, 20'h0, 8'h00, 1, "R10");
    check("R10", "id prog rejected", int'(reject_o), 1);
    cmd(4'd2, 20'h0, 8'h00, 1, "R3");
    check("R3", "wen cleared", int'(status_o), 32'h24);
    cmd(4'd13, 20'h0, 8'h00, 1, "R2");
    step(1'b0, 4'd1, 20'h0, 8'h00, 1, 1'b0, "R2");

    for (int i = 0; i < 4000; i++) begin
      bit [3:0]    c;
      bit [AW-1:0] a;
      bit          cv;
      c  = ($urandom % 3 == 0) ? 4'd1 : 4'($urandom % 14);
      a  = ($urandom % 2 == 0) ? AW'($urandom) : (AW'('1) - AW'($urandom % 20'h30000));
      cv = ($urandom % 4) != 0;
      step(cv, c, a, 8'($urandom), 1'($urandom % 3 != 0), 1'($urandom % 3 == 0),
           tag_of(c));
    end

    report();
    $finish;
  end

endmodule